// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side command decoder of a single-lane serial flash device. It watches chip select, serial clock and serial data in, captures an 8-bit opcode, and then either streams read data (identification bytes, a signature byte, manufacturer/device bytes after an address, or the status byte) or performs a control action. The control actions are setting or clearing a write-enable latch and starting a stand-in program or erase. A program or erase does not touch any storage. It only holds a write-in-progress flag for a fixed number of system clocks.

All pins are brought into a faster system clock domain, and framing is derived from their edges there. Incoming bits are taken on serial clock rising edges and outgoing bits are launched on falling edges, most significant bit first. Both clock idle levels (mode 0 and mode 3) work without configuration. The data output comes with a separate output-enable that drives an external tri-state buffer. A low output-enable means the pin floats.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: After reset the output-enable is low and the status byte reads 0x00.
- R2: Both serial clock idle levels work: input bits are taken on rising edges, output bits are launched on falling edges, and both directions are MSB first.
- R3: Opcode 0x9F streams 0xC2, 0x25, 0x34 and repeats that triple for as long as the clock runs.
- R4: Opcode 0xAB streams the byte 0x34 repeatedly.
- R5: Opcode 0x90 is followed by a 24-bit address. If the address's last bit is 0, the output alternates 0xC2, 0x34, ... starting with 0xC2. If that bit is 1, it alternates starting with 0x34.
- R6: Opcode 0x05 streams the status byte repeatedly. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 read 0. Each byte is a snapshot taken when its first bit is launched.
- R7: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it.
- R8: A control opcode (0x06, 0x04, 0x02, 0x20, 0xD8, 0xC7) takes effect only when chip select rises after a whole number of bytes. Otherwise it is discarded with no state change.
- R9: For an unrecognised opcode, output-enable stays low until the next chip select fall.
- R10: A read may be ended after any bit. Output-enable then drops, and no state changes.
- R11: Program (0x02) and erase (0x20, 0xD8, 0xC7) are accepted only while the write-enable latch is set. When accepted, write-in-progress is held for BUSY_CYCLES system clocks, and write-in-progress and the latch clear together at the end.
- R12: While write-in-progress is set, every control opcode is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data into the device |
| miso | output | 1 | Serial data out of the device |
| miso_oe | output | 1 | Output-enable for the tri-state data driver |

## Verification
Two events can land in the same system clock cycle: the busy timer expiring, which clears both write-in-progress and the write-enable latch, and the launch of the first bit of a status byte. The bench starts an erase and then clocks out ten status bytes back to back, so that one byte boundary falls close to the expiry. Each byte must read either 0x03 or 0x00, never a torn mixture. The stream must begin at 0x03, end at 0x00, and never return to 0x03 once 0x00 has appeared.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_TX, ST_CTRL, ST_REJ
  } fe_state_t;

  typedef enum logic [1:0] {
    SRC_ID, SRC_SIG, SRC_STAT, SRC_MFR
  } tx_src_t;

  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_SIG    = 8'hAB;
  localparam logic [7:0] OP_MFR    = 8'h90;
  localparam logic [7:0] OP_STAT   = 8'h05;
  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_WDIS   = 8'h04;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_ERS_S  = 8'h20;
  localparam logic [7:0] OP_ERS_B  = 8'hD8;
  localparam logic [7:0] OP_ERS_C  = 8'hC7;

  localparam logic [7:0] ID_MAKER  = 8'hC2;
  localparam logic [7:0] ID_TYPE   = 8'h25;
  localparam logic [7:0] ID_DEV    = 8'h34;

  localparam int ADDR_BITS = 24;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] pipe_q [STAGES];

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[k] <= RST_VAL;
        else if (k == 0) pipe_q[k] <= pin_i;
        else pipe_q[k] <= pipe_q[(k == 0) ? 0 : k-1];
      end
    end
  endgenerate

  assign lvl_o = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_fe_edge.sv
module spi_fe_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/spi_fe_busy.sv
module spi_fe_busy #(
  parameter int BUSY_CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic wip_o,
  output logic done_o
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wip_q, wip_d;

  always_comb begin
    cnt_d = cnt_q;
    wip_d = wip_q;
    if (wip_q) begin
      if (cnt_q == '0) wip_d = 1'b0;
      else cnt_d = cnt_q - 1'b1;
    end else if (start_i) begin
      cnt_d = LOAD;
      wip_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wip_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      wip_q <= wip_d;
    end
  end

  assign wip_o  = wip_q;
  assign done_o = wip_q && (cnt_q == '0);

  assert_start_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !wip_q);
  assert_busy_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> (cnt_q == LOAD));
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wip_q |-> (cnt_q <= LOAD));

endmodule

// File: rtl/spi_fe_cmd.sv
module spi_fe_cmd
  import spi_fe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_rise_i,
  input  logic cs_fall_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  input  logic mosi_i,
  input  logic wip_i,
  input  logic done_i,
  output logic start_o,
  output logic miso_o,
  output logic oe_o
);

  fe_state_t st_q, st_d;
  tx_src_t   src_q, src_d;
  logic [2:0] bit_q, bit_d, txc_q, txc_d;
  logic [6:0] rx_q, rx_d;
  logic [7:0] op_q, op_d, tx_q, tx_d, opc, cur;
  logic [4:0] addr_q, addr_d;
  logic [1:0] bidx_q, bidx_d;
  logic swap_q, swap_d, miso_q, miso_d, oe_q, oe_d, wel_q, wel_d;

  always_comb begin
    unique case (src_q)
      SRC_ID:   cur = (bidx_q == 2'd0) ? ID_MAKER : (bidx_q == 2'd1) ? ID_TYPE : ID_DEV;
      SRC_SIG:  cur = ID_DEV;
      SRC_STAT: cur = {6'b0, wel_q, wip_i};
      default:  cur = (bidx_q[0] ^ swap_q) ? ID_DEV : ID_MAKER;
    endcase
  end

  assign opc = {rx_q, mosi_i};

  always_comb begin
    st_d = st_q; src_d = src_q; bit_d = bit_q; txc_d = txc_q;
    rx_d = rx_q; op_d = op_q; tx_d = tx_q; addr_d = addr_q;
    bidx_d = bidx_q; swap_d = swap_q; miso_d = miso_q;
    oe_d = oe_q; wel_d = wel_q; start_o = 1'b0;
    if (cs_fall_i) begin
      st_d = ST_OPC; bit_d = '0; oe_d = 1'b0;
    end else if (cs_rise_i) begin
      if (st_q == ST_CTRL && bit_q == '0 && !wip_i) begin
        unique case (op_q)
          OP_WEN:  wel_d = 1'b1;
          OP_WDIS: wel_d = 1'b0;
          default: start_o = wel_q;
        endcase
      end
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (sclk_rise_i) begin
      unique case (st_q)
        ST_OPC: begin
          bit_d = bit_q + 1'b1;
          rx_d  = {rx_q[5:0], mosi_i};
          if (bit_q == 3'd7) begin
            op_d = opc; addr_d = '0; bidx_d = '0; txc_d = '0; swap_d = 1'b0;
            unique case (opc)
              OP_RDID: begin st_d = ST_TX; src_d = SRC_ID;   end
              OP_SIG:  begin st_d = ST_TX; src_d = SRC_SIG;  end
              OP_STAT: begin st_d = ST_TX; src_d = SRC_STAT; end
              OP_MFR:  begin st_d = ST_ADDR; src_d = SRC_MFR; end
              OP_WEN, OP_WDIS, OP_PROG, OP_ERS_S, OP_ERS_B, OP_ERS_C: st_d = ST_CTRL;
              default: st_d = ST_REJ;
            endcase
          end
        end
        ST_ADDR: begin
          addr_d = addr_q + 1'b1;
          if (addr_q == 5'(ADDR_BITS - 1)) begin
            swap_d = mosi_i; st_d = ST_TX;
          end
        end
        ST_CTRL: bit_d = bit_q + 1'b1;
        default: ;
      endcase
    end else if (sclk_fall_i && st_q == ST_TX) begin
      oe_d = 1'b1;
      if (txc_q == '0) begin
        miso_d = cur[7];
        tx_d   = {cur[6:0], 1'b0};
        txc_d  = 3'd7;
        bidx_d = (src_q == SRC_ID && bidx_q == 2'd2) ? 2'd0 : bidx_q + 1'b1;
      end else begin
        miso_d = tx_q[7];
        tx_d   = {tx_q[6:0], 1'b0};
        txc_d  = txc_q - 1'b1;
      end
    end
    if (done_i) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; src_q <= SRC_ID; bit_q <= '0; txc_q <= '0;
      rx_q <= '0; op_q <= '0; tx_q <= '0; addr_q <= '0; bidx_q <= '0;
      swap_q <= 1'b0; miso_q <= 1'b0; oe_q <= 1'b0; wel_q <= 1'b0;
    end else begin
      st_q <= st_d; src_q <= src_d; bit_q <= bit_d; txc_q <= txc_d;
      rx_q <= rx_d; op_q <= op_d; tx_q <= tx_d; addr_q <= addr_d; bidx_q <= bidx_d;
      swap_q <= swap_d; miso_q <= miso_d; oe_q <= oe_d; wel_q <= wel_d;
    end
  end

  assign miso_o = miso_q;
  assign oe_o   = oe_q;

  assert_oe_only_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st_q == ST_TX));
  assert_rej_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REJ) |-> !oe_q);
  assert_cs_end_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> !oe_q);
  assert_done_clears_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !wel_q);
  assert_busy_keeps_wel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_i && !done_i) |=> $stable(wel_q));

endmodule

// File: rtl/spi_flash_cmd_fe.sv
module spi_flash_cmd_fe #(
  parameter int BUSY_CYCLES = 600,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);

  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  logic [2:0] lvl;
  logic [1:0] rise, fall;
  logic       start, wip, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  spi_fe_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .pin_i({cs_n, sclk, mosi}), .lvl_o(lvl));

  spi_fe_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_s_n), .lvl_i(lvl[2:1]), .rise_o(rise), .fall_o(fall));

  spi_fe_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_s_n), .start_i(start), .wip_o(wip), .done_o(done));

  spi_fe_cmd u_cmd (
    .clk(clk), .rst_n(rst_s_n),
    .cs_rise_i(rise[1]), .cs_fall_i(fall[1]),
    .sclk_rise_i(rise[0]), .sclk_fall_i(fall[0]),
    .mosi_i(lvl[0]), .wip_i(wip), .done_i(done),
    .start_o(start), .miso_o(miso), .oe_o(miso_oe));

endmodule

// File: tb/spi_flash_cmd_fe_tb.sv
module spi_flash_cmd_fe_tb_top;

  logic clk, rst_n, cs_n, sclk, mosi, miso, miso_oe;
  int   errs = 0;
  int   tot = 0;
  logic oe_any;

  spi_flash_cmd_fe dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] id_b(input int k);
    return (k % 3 == 0) ? 8'hC2 : (k % 3 == 1) ? 8'h25 : 8'h34;
  endfunction

  function automatic logic [7:0] mfr_b(input int k, input bit lsb);
    return (((k % 2) == 1) ^ lsb) ? 8'h34 : 8'hC2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tot++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (8) begin
      @(negedge clk);
      if (miso_oe) oe_any = 1'b1;
    end
  endtask

  task automatic xfer(input bit m3, input int nbits, input logic [127:0] tx,
                      output logic [127:0] rx);
    rx = '0;
    sclk = m3; wait_h();
    oe_any = 1'b0;
    cs_n = 1'b0; wait_h();
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; mosi = tx[nbits-1-i]; wait_h();
      rx = {rx[126:0], miso};
      sclk = 1'b1; wait_h();
    end
    if (!m3) begin sclk = 1'b0; wait_h(); end
    cs_n = 1'b1; wait_h();
  endtask

  task automatic rd_stat(input bit m3, output logic [7:0] s);
    logic [127:0] rx;
    xfer(m3, 16, {112'b0, 8'h05, 8'h00}, rx);
    s = rx[7:0];
  endtask

  task automatic cmd8(input bit m3, input logic [7:0] op, input int nbits);
    logic [127:0] rx;
    xfer(m3, nbits, {op, 120'b0} >> (128 - nbits), rx);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errs++; tot++;
    $display("FAIL watchdog (all requirements) act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, tot);
    $finish;
  end

  initial begin
    logic [127:0] rx;
    logic [7:0]   s;
    bit           seen0, bad;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; oe_any = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", miso_oe, 0);
    rd_stat(0, s); chk("R1 status after reset", s, 8'h00);

    xfer(1, 40, {88'b0, 8'h9F, 32'b0}, rx);
    for (int k = 0; k < 4; k++) chk("R3 id mode3 (R2)", rx[(3-k)*8 +: 8], id_b(k));
    xfer(0, 64, {64'b0, 8'h9F, 56'b0}, rx);
    for (int k = 0; k < 7; k++) chk("R3 id mode0 (R2)", rx[(6-k)*8 +: 8], id_b(k));
    xfer(0, 24, {104'b0, 8'hAB, 16'b0}, rx);
    chk("R4 signature", rx[15:0], 16'h3434);
    xfer(1, 56, {72'b0, 8'h90, 24'h000000, 24'b0}, rx);
    for (int k = 0; k < 3; k++) chk("R5 lsb0", rx[(2-k)*8 +: 8], mfr_b(k, 0));
    xfer(0, 48, {80'b0, 8'h90, 24'h000001, 16'b0}, rx);
    for (int k = 0; k < 2; k++) chk("R5 lsb1", rx[(1-k)*8 +: 8], mfr_b(k, 1));

    cmd8(0, 8'h06, 8);  rd_stat(1, s); chk("R7 wen sets latch (R6)", s, 8'h02);
    cmd8(1, 8'h04, 12); rd_stat(0, s); chk("R8 truncated wdis discarded", s, 8'h02);
    cmd8(0, 8'h04, 8);  rd_stat(0, s); chk("R7 wdis clears latch", s, 8'h00);
    cmd8(1, 8'h06, 9);  rd_stat(1, s); chk("R8 wen on 9 bits discarded", s, 8'h00);

    xfer(1, 24, {104'b0, 8'h5A, 16'hFFFF}, rx);
    chk("R9 unknown opcode oe", oe_any, 0);
    rd_stat(0, s); chk("R9 data out after unknown", s, 8'h00);

    cmd8(0, 8'h06, 8);
    xfer(0, 13, {115'b0, 8'h9F, 5'b0}, rx);
    chk("R10 oe low after aborted read", miso_oe, 0);
    rd_stat(1, s); chk("R10 no side effect", s, 8'h02);

    cmd8(0, 8'h04, 8);
    xfer(0, 32, {96'b0, 8'h02, 24'h001000}, rx);
    rd_stat(0, s); chk("R11 program without latch", s, 8'h00);

    cmd8(1, 8'h06, 8);
    xfer(1, 32, {96'b0, 8'h02, 24'h001000}, rx);
    rd_stat(0, s); chk("R11 program busy", s, 8'h03);
    cmd8(0, 8'h04, 8);
    rd_stat(0, s); chk("R12 wdis ignored while busy", s, 8'h03);
    repeat (700) @(negedge clk);
    rd_stat(1, s); chk("R11 busy ends, latch cleared", s, 8'h00);

    cmd8(0, 8'h06, 8);
    xfer(0, 32, {96'b0, 8'h20, 24'h002000}, rx);
    xfer(1, 88, {40'b0, 8'h05, 80'b0}, rx);
    seen0 = 1'b0; bad = 1'b0;
    for (int k = 0; k < 10; k++) begin
      s = rx[(9-k)*8 +: 8];
      if (s == 8'h00) seen0 = 1'b1;
      else if (s != 8'h03 || seen0) bad = 1'b1;
    end
    chk("R6 status stream across expiry", {bad, rx[79:72], rx[7:0]}, {1'b0, 8'h03, 8'h00});

    cmd8(1, 8'h06, 8); cmd8(1, 8'hC7, 8);
    rd_stat(0, s); chk("R11 chip erase busy", s, 8'h03);
    repeat (700) @(negedge clk);
    rd_stat(0, s); chk("R11 chip erase done", s, 8'h00);

    for (int t = 0; t < 24; t++) begin
      int sel, nb;
      bit m3, lsb;
      logic [23:0] ad;
      logic [31:0] got, exp;
      sel = $urandom_range(0, 3); nb = $urandom_range(1, 4);
      m3 = 1'($urandom_range(0, 1)); ad = 24'($urandom); lsb = ad[0];
      got = '0; exp = '0;
      case (sel)
        0: begin
          xfer(m3, 8 + nb*8, {8'h9F, 120'b0} >> (120 - nb*8), rx);
          for (int k = 0; k < nb; k++) exp = {exp[23:0], id_b(k)};
        end
        1: begin
          xfer(m3, 8 + nb*8, {8'hAB, 120'b0} >> (120 - nb*8), rx);
          for (int k = 0; k < nb; k++) exp = {exp[23:0], 8'h34};
        end
        2: begin
          xfer(m3, 32 + nb*8, {8'h90, ad, 96'b0} >> (96 - nb*8), rx);
          for (int k = 0; k < nb; k++) exp = {exp[23:0], mfr_b(k, lsb)};
        end
        default: begin
          xfer(m3, 8 + nb*8, {8'h05, 120'b0} >> (120 - nb*8), rx);
          exp = '0;
        end
      endcase
      got = rx[31:0] & ((nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (nb*8)) - 1));
      chk("R2 random read (R3/R4/R5/R6 data)", got, exp);
    end

    $display("Result: errors=%0d of %0d checks", errs, tot);
    $finish;
  end

endmodule